// File: doc/BRIEF.md
# Relay Command Verifier

This block owns a bank of drive flip-flops, one per latching relay control point. A processor-side request names a point and an action: operate or release. The block accepts one request at a time. It updates the flip-flop for that point, which then keeps its value because the relay latches. It then opens a timed window and waits for the relay's own contact to send a confirmation pulse back on that point's return line. The window length is a programmable count of clock cycles.

Each command ends with a single report cycle. The report gives pass or fail, the point index and the action. A release has to be confirmed in the same way as an operate. Return lines are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector before the block uses it. A detected edge is flagged as a spurious return, with the lowest such point index, when it arrives:
- on a point other than the one under test, or
- outside the waiting phase.

The sequencer has four states:
- IDLE: ready for a command.
- DRIVE: the flip-flop is written.
- WAIT: the window is counting.
- REPORT: one cycle of result.

It has five transitions:
- ACCEPT: IDLE to DRIVE, on a request.
- ARM: DRIVE to WAIT, always.
- CONFIRM: WAIT to REPORT, with pass, on an edge from the target point.
- EXPIRE: WAIT to REPORT, with fail, when the count is zero and no edge has arrived.
- RETIRE: REPORT to IDLE.

Top module: `relay_cmd_verifier`

## Requirements
- R1: After reset all drive outputs are 0, `req_ready` is 1, and neither `rpt_valid` nor `spur_valid` is asserted.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the edge that ends the report cycle. Requests offered while `req_ready` is 0 are ignored.
- R3: With `req_operate`=1 (operate), the drive bit of the named point becomes 1. With `req_operate`=0 (release), it becomes 0. The new value is visible after the second rising edge counted from the accept edge. All other drive bits are unchanged.
- R4: Drive bits hold their value after a command completes and change only through an accepted command.
- R5: A rising edge on the target point's return line is detected in a WAIT cycle when the line was sampled high at edge E+a and low at the edge before it, where E is the accept edge. In that case the block makes a pass report (`rpt_pass`=1). Each report lasts exactly one cycle.
- R6: `win_cycles`=W is sampled at the accept edge. When no edge is detected, a fail report (`rpt_pass`=0) is visible in the cycle after edge E+W+2. A return line that rises before edge E+a is confirmed for any a from 0 to W. The report then appears after edge E+a+2.
- R7: Every report gives `rpt_point` and `rpt_operate`, equal to the point and action of the command, with 1 meaning operate.
- R8: A detected return edge on a point that is not under test, or one detected outside WAIT, raises `spur_valid` for one cycle in the following cycle. `spur_point` then gives the lowest such point index.
- R9: Return edges on other points during WAIT do not confirm the pending command, and they do not change its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | High when a command can be taken |
| req_point | input | IDX_W | Point addressed by the command |
| req_operate | input | 1 | 1 = operate, 0 = release |
| win_cycles | input | WIN_W | Confirmation window length in cycles |
| relay_drive | output | N_POINTS | Drive flip-flop outputs, one per point |
| conf_pulse | input | N_POINTS | Asynchronous confirmation return lines |
| rpt_valid | output | 1 | One-cycle command report |
| rpt_pass | output | 1 | 1 = confirmed, 0 = window expired |
| rpt_point | output | IDX_W | Point of the reported command |
| rpt_operate | output | 1 | Action of the reported command |
| spur_valid | output | 1 | Unexpected return detected |
| spur_point | output | IDX_W | Lowest index with an unexpected return |

## Verification
On every cycle, the assertions check the following:
- Reports and detected edges each last a single cycle.
- At most one drive bit changes per cycle, and drive bits change only on a write.
- The window counter never exceeds the sampled length.
- A report always matches the drive bit it concerns.

Only the bench scenarios can show the end-to-end timing, because it depends on the synchronizer delay. That covers:
- the exact report latency for a missing pulse;
- the latest pulse that still passes;
- a pulse one cycle too late being turned into a fail plus a spurious flag;
- the choice of the lowest index when several spurious returns land together.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rcv_return_sync.sv
module rcv_return_sync #(
    parameter int N_POINTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_POINTS-1:0] line_in,
    output logic [N_POINTS-1:0] rise
);
    for (genvar g = 0; g < N_POINTS; g++) begin : g_pt
        logic meta_q, sync_q, hist_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= line_in[g];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end
        assign rise[g] = sync_q & ~hist_q;

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]); // R5
    end
endmodule

// File: rtl/rcv_drive_bank.sv
module rcv_drive_bank #(
    parameter int N_POINTS = 8,
    localparam int IDX_W = (N_POINTS > 1) ? $clog2(N_POINTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_val,
    output logic [N_POINTS-1:0] drive
);
    for (genvar g = 0; g < N_POINTS; g++) begin : g_ff
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                drive[g] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                drive[g] <= wr_val;
        end
    end

    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(drive)); // R4
    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive ^ $past(drive)) <= 1); // R3
endmodule

// File: rtl/rcv_lowest_set.sv
module rcv_lowest_set #(
    parameter int N_POINTS = 8,
    localparam int IDX_W = (N_POINTS > 1) ? $clog2(N_POINTS) : 1
) (
    input  logic [N_POINTS-1:0] vec,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_POINTS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rcv_seq.sv
module rcv_seq
    import rcv_pkg::*;
#(
    parameter int N_POINTS = 8,
    parameter int WIN_W    = 8,
    localparam int IDX_W = (N_POINTS > 1) ? $clog2(N_POINTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [IDX_W-1:0]    req_point,
    input  logic                req_operate,
    input  logic [WIN_W-1:0]    win_cycles,
    input  logic [N_POINTS-1:0] rise,
    output logic                req_ready,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic                wr_val,
    output logic [N_POINTS-1:0] watch_mask,
    output logic                rpt_valid,
    output logic                rpt_pass,
    output logic [IDX_W-1:0]    rpt_point,
    output logic                rpt_operate
);
    seq_state_t       st_q, st_d;
    logic [WIN_W-1:0] cnt_q, win_q;
    logic [IDX_W-1:0] pt_q;
    logic             op_q, pass_q;
    logic             take, hit, expire;

    assign take   = (st_q == ST_IDLE) && req_valid;
    assign hit    = (st_q == ST_WAIT) && rise[pt_q];
    assign expire = (st_q == ST_WAIT) && !rise[pt_q] && (cnt_q == '0);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (take) st_d = ST_DRIVE;          // ACCEPT
            ST_DRIVE:  st_d = ST_WAIT;                     // ARM
            ST_WAIT:   if (hit || expire) st_d = ST_REPORT; // CONFIRM / EXPIRE
            ST_REPORT: st_d = ST_IDLE;                     // RETIRE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            win_q  <= '0;
            pt_q   <= '0;
            op_q   <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take) begin
                cnt_q <= win_cycles;
                win_q <= win_cycles;
                pt_q  <= req_point;
                op_q  <= req_operate;
            end else if (st_q == ST_WAIT) begin
                if (hit)
                    pass_q <= 1'b1;
                else if (expire)
                    pass_q <= 1'b0;
                else
                    cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        wr_en       = 1'b0;
        watch_mask  = '0;
        rpt_valid   = 1'b0;
        unique case (st_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_DRIVE:  wr_en = 1'b1;
            ST_WAIT:   watch_mask[pt_q] = 1'b1;
            ST_REPORT: rpt_valid = 1'b1;
        endcase
        wr_idx      = pt_q;
        wr_val      = op_q;
        rpt_pass    = pass_q;
        rpt_point   = pt_q;
        rpt_operate = op_q;
    end

    AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid); // R5
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> (cnt_q <= win_q)); // R6
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(pt_q) || (st_q == ST_IDLE)); // R2
endmodule

// File: rtl/relay_cmd_verifier.sv
module relay_cmd_verifier #(
    parameter int N_POINTS = 8,
    parameter int WIN_W    = 8,
    localparam int IDX_W = (N_POINTS > 1) ? $clog2(N_POINTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [IDX_W-1:0]    req_point,
    input  logic                req_operate,
    input  logic [WIN_W-1:0]    win_cycles,
    output logic [N_POINTS-1:0] relay_drive,
    input  logic [N_POINTS-1:0] conf_pulse,
    output logic                rpt_valid,
    output logic                rpt_pass,
    output logic [IDX_W-1:0]    rpt_point,
    output logic                rpt_operate,
    output logic                spur_valid,
    output logic [IDX_W-1:0]    spur_point
);
    logic [N_POINTS-1:0] rise, watch_mask, stray;
    logic                wr_en, wr_val, stray_any;
    logic [IDX_W-1:0]    wr_idx, stray_idx;

    rcv_return_sync #(.N_POINTS(N_POINTS)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(conf_pulse), .rise(rise)
    );

    rcv_seq #(.N_POINTS(N_POINTS), .WIN_W(WIN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_point(req_point), .req_operate(req_operate),
        .win_cycles(win_cycles), .rise(rise), .req_ready(req_ready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .watch_mask(watch_mask),
        .rpt_valid(rpt_valid), .rpt_pass(rpt_pass),
        .rpt_point(rpt_point), .rpt_operate(rpt_operate)
    );

    rcv_drive_bank #(.N_POINTS(N_POINTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_val(wr_val), .drive(relay_drive)
    );

    assign stray = rise & ~watch_mask;

    rcv_lowest_set #(.N_POINTS(N_POINTS)) u_low (
        .vec(stray), .any(stray_any), .idx(stray_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spur_valid <= 1'b0;
            spur_point <= '0;
        end else begin
            spur_valid <= stray_any;
            spur_point <= stray_idx;
        end
    end

    AST_REPORT_MATCHES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (relay_drive[rpt_point] == rpt_operate)); // R7
    AST_READY_LOW_IN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> !req_ready); // R2
endmodule

// File: tb/test_relay_cmd_verifier.sv
module test_relay_cmd_verifier;
    localparam int NP = 8;
    localparam int WW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_point = '0;
    logic          req_operate = 1'b0;
    logic [WW-1:0] win_cycles = '0;
    logic [NP-1:0] relay_drive;
    logic [NP-1:0] conf_pulse = '0;
    logic          rpt_valid, rpt_pass, rpt_operate, spur_valid;
    logic [IW-1:0] rpt_point, spur_point;

    int n_chk = 0, n_fail = 0, spur_cnt = 0, spur_last = -1;
    bit finished = 0;
    logic [NP-1:0] exp_drive = '0;

    always #4 clk = ~clk;

    relay_cmd_verifier #(.N_POINTS(NP), .WIN_W(WW)) i_relay_cmd_verifier (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_point(req_point), .req_operate(req_operate), .win_cycles(win_cycles),
        .relay_drive(relay_drive), .conf_pulse(conf_pulse),
        .rpt_valid(rpt_valid), .rpt_pass(rpt_pass), .rpt_point(rpt_point),
        .rpt_operate(rpt_operate), .spur_valid(spur_valid), .spur_point(spur_point)
    );

    always @(negedge clk) begin
        if (rst_n && spur_valid) begin
            spur_cnt++;
            spur_last = int'(spur_point);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One command; pulse_at = a means the target line is set at negedge a
    // (0 = together with the request), -1 = no pulse. other_at likewise for other_pt.
    task automatic run_cmd(input int pt, input bit op, input int w, input int pulse_at,
                           input int other_pt, input int other_at);
        int k = 0;
        int exp_k;
        bit seen = 0;
        bit exp_pass;
        @(negedge clk);
        req_valid = 1'b1; req_point = IW'(pt); req_operate = op; win_cycles = WW'(w);
        if (pulse_at == 0) conf_pulse[pt] = 1'b1;
        if (other_at == 0) conf_pulse[other_pt] = 1'b1;
        exp_pass = (pulse_at >= 0) && (pulse_at <= w);
        exp_k = exp_pass ? pulse_at + 3 : w + 3;
        while (!seen && k < w + 12) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                req_valid = 1'b0;
                chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
                // a second request offered while busy must be ignored
                req_valid = 1'b1; req_point = IW'((pt + 1) % NP); req_operate = ~op;
            end
            if (k == 2) begin
                req_valid = 1'b0;
                exp_drive[pt] = op;
                chk(relay_drive == exp_drive, "R3 drive", int'(relay_drive), int'(exp_drive));
            end
            if (k == pulse_at) conf_pulse[pt] = 1'b1;
            if (k == pulse_at + 1) conf_pulse[pt] = 1'b0;
            if (k == other_at) conf_pulse[other_pt] = 1'b1;
            if (k == other_at + 1) conf_pulse[other_pt] = 1'b0;
            if (rpt_valid) seen = 1;
        end
        chk(seen && k == exp_k, "R6 latency", k, exp_k);
        chk(rpt_pass == exp_pass, exp_pass ? "R5 pass" : "R6 fail", int'(rpt_pass), int'(exp_pass));
        chk(int'(rpt_point) == pt && rpt_operate == op, "R7 fields",
            int'(rpt_point) * 2 + int'(rpt_operate), pt * 2 + int'(op));
        @(negedge clk);
        chk(rpt_valid == 1'b0 && req_ready == 1'b1, "R5 single report", int'(rpt_valid), 0);
        conf_pulse = '0;
        repeat (3) @(negedge clk);
        chk(relay_drive == exp_drive, "R4 hold", int'(relay_drive), int'(exp_drive));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int sc;
        repeat (3) @(negedge clk);
        chk(relay_drive == '0, "R1 drive", int'(relay_drive), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rpt_valid == 1'b0 && spur_valid == 1'b0, "R1 idle",
            int'(req_ready), 1);

        // sweep: every point, both actions, several windows, no pulse / earliest / latest
        for (int w = 0; w < 4; w++) begin
            for (int pt = 0; pt < NP; pt++) begin
                for (int o = 0; o < 2; o++) begin
                    run_cmd(pt, o[0], w, -1, 0, -1);
                    run_cmd(pt, o[0], w, 0, 0, -1);
                    run_cmd(pt, ~o[0], w, w, 0, -1);
                end
            end
        end

        // one cycle too late: fail, then the late edge is flagged as spurious
        sc = spur_cnt;
        run_cmd(5, 1'b1, 2, 3, 0, -1);
        chk(spur_cnt == sc + 1 && spur_last == 5, "R8 late edge", spur_cnt - sc, 1);

        // other point rises during WAIT: no confirmation, flagged spurious
        sc = spur_cnt;
        run_cmd(2, 1'b0, 4, -1, 6, 1);
        chk(spur_cnt == sc + 1 && spur_last == 6, "R9 other point", spur_last, 6);
        sc = spur_cnt;
        run_cmd(3, 1'b1, 5, 4, 1, 2);
        chk(spur_cnt == sc + 1 && spur_last == 1, "R9 pass unaffected", spur_last, 1);

        // idle pulses on two points at once: lowest index reported
        sc = spur_cnt;
        @(negedge clk);
        conf_pulse[5] = 1'b1; conf_pulse[2] = 1'b1;
        @(negedge clk);
        conf_pulse = '0;
        repeat (5) @(negedge clk);
        chk(spur_cnt == sc + 1 && spur_last == 2, "R8 lowest index", spur_last, 2);
        chk(relay_drive == exp_drive && req_ready, "R4 idle pulses", int'(relay_drive), int'(exp_drive));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule